// File: doc/BRIEF.md
# Registered Bus Transceiver with Live or Stored Transfer

This block couples two 8-bit buses, A and B. Each bus has a capture register that samples that bus whenever its capture strobe is high at a rising clock edge. A single active-low enable and a direction input decide which bus, if any, the block drives. Whichever bus is driven takes its data from the opposite side. That data is either the opposite bus as it is right now (live) or the value the opposite side's register last captured (stored). A per-direction select input makes that choice.

Each bus is modelled as three separate pieces: an input vector, an output vector and an output-enable flag. There are no bidirectional ports, so the block fits inside a chip's on-die routing fabric. The decoding allows at most one bus to be driven at a time. A parameter adds an inverting stage to both output paths. The output paths are combinational, so a change of select, enable, direction or live data shows up in the same cycle.

Top module: `bus_xcvr`

## Requirements
- R1: On a rising `clk_i` edge with `cap_a_i` high, the A-side register takes `a_i`. With `cap_a_i` low it holds its value. Capture does not depend on `oe_ni`, `dir_i` or the select inputs.
- R2: On a rising `clk_i` edge with `cap_b_i` high, the B-side register takes `b_i`. With `cap_b_i` low it holds its value. Capture does not depend on `oe_ni`, `dir_i` or the select inputs.
- R3: While `rst_ni` is low, both registers are cleared to zero asynchronously.
- R4: With `oe_ni` high, neither bus is driven. `a_oe_o` and `b_oe_o` are 0, and `a_o` and `b_o` are all zeros.
- R5: With `oe_ni` low and `dir_i` = 0, the A bus is driven: `a_oe_o` = 1. `a_o` carries `b_i` when `sel_b2a_i` = 0, or the B-side register when `sel_b2a_i` = 1. The B bus is not driven (`b_oe_o` = 0, `b_o` = 0).
- R6: With `oe_ni` low and `dir_i` = 1, the B bus is driven: `b_oe_o` = 1. `b_o` carries `a_i` when `sel_a2b_i` = 0, or the A-side register when `sel_a2b_i` = 1. The A bus is not driven (`a_oe_o` = 0, `a_o` = 0).
- R7: `a_oe_o` and `b_oe_o` are never both 1.
- R8: With `INVERT` = 1, each driven output is the bitwise complement of the data chosen under R5 or R6. Undriven outputs stay all zeros, and all other behaviour is unchanged.
- R9: A change on a select input moves the driven output from one source to the other within the same cycle, with no clock edge needed.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Capture clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| a_i | input | W | Value present on bus A |
| b_i | input | W | Value present on bus B |
| cap_a_i | input | 1 | Capture strobe for the A-side register |
| cap_b_i | input | 1 | Capture strobe for the B-side register |
| sel_a2b_i | input | 1 | Source for B output: 0 live A, 1 stored A |
| sel_b2a_i | input | 1 | Source for A output: 0 live B, 1 stored B |
| oe_ni | input | 1 | Output enable, active low |
| dir_i | input | 1 | Direction: 0 drive A, 1 drive B |
| a_o | output | W | Data driven onto bus A |
| a_oe_o | output | 1 | Bus A drive enable |
| b_o | output | W | Data driven onto bus B |
| b_oe_o | output | 1 | Bus B drive enable |

## Verification
Each direction is tried with live and stored sources. The stored value is always different from the live value, so a swapped or stuck mux leg shows up. Captures are made under isolation and in the opposite direction, then read back through the stored path, which shows whether capture is gated by enable or direction. Captures are also held off while the bus value changes, which separates a capture from a hold. A second instance built with inversion runs the same stimulus, which separates a correct complement from a missing one and from an inverted idle level.

// File: rtl/bus_xcvr_pkg.sv
package bus_xcvr_pkg;
  typedef enum logic [1:0] {
    DRV_NONE = 2'b00,
    DRV_A    = 2'b01,
    DRV_B    = 2'b10
  } drive_e;
endpackage

// File: rtl/bus_xcvr_store.sv
module bus_xcvr_store #(
  parameter int W = 8
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         cap_i,
  input  logic [W-1:0] d_i,
  output logic [W-1:0] q_o
);
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)    q_o <= '0;
    else if (cap_i) q_o <= d_i;
  end
endmodule

// File: rtl/bus_xcvr_dec.sv
module bus_xcvr_dec
  import bus_xcvr_pkg::*;
(
  input  logic   oe_ni,
  input  logic   dir_i,
  output drive_e drive_o
);
  always_comb begin
    if (oe_ni)      drive_o = DRV_NONE;
    else if (dir_i) drive_o = DRV_B;
    else            drive_o = DRV_A;
  end
endmodule

// File: rtl/bus_xcvr_route.sv
module bus_xcvr_route #(
  parameter int W      = 8,
  parameter bit INVERT = 1'b0
) (
  input  logic [W-1:0] live_i,
  input  logic [W-1:0] stored_i,
  input  logic         sel_stored_i,
  input  logic         en_i,
  output logic [W-1:0] data_o
);
  logic [W-1:0] pick;
  logic [W-1:0] pol;

  // single-level mux: select edge switches sources with no mixed state
  assign pick = sel_stored_i ? stored_i : live_i;

  generate
    if (INVERT) begin : g_inv
      assign pol = ~pick;
    end else begin : g_pass
      assign pol = pick;
    end
  endgenerate

  // undriven bus idles at zero regardless of polarity
  assign data_o = en_i ? pol : '0;
endmodule

// File: rtl/bus_xcvr.sv
module bus_xcvr
  import bus_xcvr_pkg::*;
#(
  parameter int W      = 8,
  parameter bit INVERT = 1'b0
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic [W-1:0] a_i,
  input  logic [W-1:0] b_i,
  input  logic         cap_a_i,
  input  logic         cap_b_i,
  input  logic         sel_a2b_i,
  input  logic         sel_b2a_i,
  input  logic         oe_ni,
  input  logic         dir_i,
  output logic [W-1:0] a_o,
  output logic         a_oe_o,
  output logic [W-1:0] b_o,
  output logic         b_oe_o
);
  logic [W-1:0] reg_a, reg_b;
  drive_e       drive;

  bus_xcvr_store #(.W(W)) u_store_a (
    .clk_i(clk_i), .rst_ni(rst_ni), .cap_i(cap_a_i), .d_i(a_i), .q_o(reg_a)
  );
  bus_xcvr_store #(.W(W)) u_store_b (
    .clk_i(clk_i), .rst_ni(rst_ni), .cap_i(cap_b_i), .d_i(b_i), .q_o(reg_b)
  );

  bus_xcvr_dec u_dec (.oe_ni(oe_ni), .dir_i(dir_i), .drive_o(drive));

  assign a_oe_o = (drive == DRV_A);
  assign b_oe_o = (drive == DRV_B);

  bus_xcvr_route #(.W(W), .INVERT(INVERT)) u_route_b2a (
    .live_i(b_i), .stored_i(reg_b), .sel_stored_i(sel_b2a_i),
    .en_i(a_oe_o), .data_o(a_o)
  );
  bus_xcvr_route #(.W(W), .INVERT(INVERT)) u_route_a2b (
    .live_i(a_i), .stored_i(reg_a), .sel_stored_i(sel_a2b_i),
    .en_i(b_oe_o), .data_o(b_o)
  );
endmodule

// File: rtl/bus_xcvr_chk.sv
module bus_xcvr_chk #(
  parameter int W      = 8,
  parameter bit INVERT = 1'b0
) (
  input logic         clk_i,
  input logic         rst_ni,
  input logic [W-1:0] a_i,
  input logic [W-1:0] b_i,
  input logic         cap_a_i,
  input logic         cap_b_i,
  input logic         sel_a2b_i,
  input logic         sel_b2a_i,
  input logic         oe_ni,
  input logic         dir_i,
  input logic [W-1:0] a_o,
  input logic         a_oe_o,
  input logic [W-1:0] b_o,
  input logic         b_oe_o
);
  localparam logic [W-1:0] PMASK = INVERT ? {W{1'b1}} : {W{1'b0}};

  p_one_side_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(a_oe_o && b_oe_o));

  p_isolate_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    oe_ni |-> (!a_oe_o && !b_oe_o && a_o == '0 && b_o == '0));

  p_live_to_a_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!oe_ni && !dir_i && !sel_b2a_i) |-> (a_oe_o && !b_oe_o && a_o == (b_i ^ PMASK)));

  p_live_to_b_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!oe_ni && dir_i && !sel_a2b_i) |-> (b_oe_o && !a_oe_o && b_o == (a_i ^ PMASK)));

  p_cap_a_r1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cap_a_i |=> (!(b_oe_o && sel_a2b_i) || b_o == ($past(a_i) ^ PMASK)));

  p_cap_b_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cap_b_i |=> (!(a_oe_o && sel_b2a_i) || a_o == ($past(b_i) ^ PMASK)));
endmodule

bind bus_xcvr bus_xcvr_chk #(.W(W), .INVERT(INVERT)) u_chk (.*);

// File: tb/bus_xcvr_tb_top.sv
`timescale 1ns/1ps
module bus_xcvr_tb_top;
  localparam int W = 8;

  logic         clk = 1'b0;
  logic         rst_n;
  logic [W-1:0] a_in, b_in;
  logic         cap_a, cap_b, sel_a2b, sel_b2a, oe_n, dir;
  logic [W-1:0] a_out, b_out, a_out_n, b_out_n;
  logic         a_oe, b_oe, a_oe_n, b_oe_n;

  int n_checks = 0;
  int n_fail   = 0;
  logic [W-1:0] m_ra, m_rb;

  always #2 clk = ~clk;

  bus_xcvr #(.W(W), .INVERT(1'b0)) dut_i (
    .clk_i(clk), .rst_ni(rst_n), .a_i(a_in), .b_i(b_in),
    .cap_a_i(cap_a), .cap_b_i(cap_b), .sel_a2b_i(sel_a2b), .sel_b2a_i(sel_b2a),
    .oe_ni(oe_n), .dir_i(dir),
    .a_o(a_out), .a_oe_o(a_oe), .b_o(b_out), .b_oe_o(b_oe)
  );

  bus_xcvr #(.W(W), .INVERT(1'b1)) dut_inv_i (
    .clk_i(clk), .rst_ni(rst_n), .a_i(a_in), .b_i(b_in),
    .cap_a_i(cap_a), .cap_b_i(cap_b), .sel_a2b_i(sel_a2b), .sel_b2a_i(sel_b2a),
    .oe_ni(oe_n), .dir_i(dir),
    .a_o(a_out_n), .a_oe_o(a_oe_n), .b_o(b_out_n), .b_oe_o(b_oe_n)
  );

  task automatic check(input string req, input logic [W-1:0] got, input logic [W-1:0] exp);
    n_checks++;
    if (got !== exp) begin
      n_fail++;
      $display("FAIL %s: got %h expected %h", req, got, exp);
    end
  endtask

  // drive at negedge, settle, sample well before next posedge
  task automatic settle();
    #1;
  endtask

  task automatic capture(input logic ca, input logic cb);
    @(negedge clk);
    cap_a = ca; cap_b = cb;
    @(posedge clk);
    if (ca) m_ra = a_in;
    if (cb) m_rb = b_in;
    @(negedge clk);
    cap_a = 1'b0; cap_b = 1'b0;
  endtask

  task automatic t_reset();
    oe_n = 1'b0; dir = 1'b0; sel_b2a = 1'b1;
    settle();
    check("R3 stored B after reset", a_out, '0);
    dir = 1'b1; sel_a2b = 1'b1;
    settle();
    check("R3 stored A after reset", b_out, '0);
  endtask

  task automatic t_isolation();
    @(negedge clk);
    oe_n = 1'b1; a_in = 8'h5a; b_in = 8'hc3; dir = 1'b0;
    settle();
    check("R4 a_o idle", a_out, '0);
    check("R4 a_oe idle", {7'd0, a_oe}, '0);
    dir = 1'b1;
    settle();
    check("R4 b_o idle", b_out, '0);
    check("R4 b_oe idle", {7'd0, b_oe}, '0);
    check("R8 inverted idle", a_out_n | b_out_n, '0);
    // capture under isolation must still happen (R1, R2)
    capture(1'b1, 1'b1);
  endtask

  task automatic t_live_and_stored_to_a();
    @(negedge clk);
    oe_n = 1'b0; dir = 1'b0; sel_b2a = 1'b0; b_in = 8'h3c;
    settle();
    check("R5 live B to A", a_out, 8'h3c);
    check("R5 a_oe", {7'd0, a_oe}, 8'd1);
    check("R5 B undriven", b_out, '0);
    check("R7 b_oe low", {7'd0, b_oe}, '0);
    sel_b2a = 1'b1;
    settle();
    check("R2 stored B under isolation", a_out, m_rb);
    check("R8 inverted stored B", a_out_n, ~m_rb);
  endtask

  task automatic t_live_and_stored_to_b();
    @(negedge clk);
    oe_n = 1'b0; dir = 1'b1; sel_a2b = 1'b0; a_in = 8'h81;
    settle();
    check("R6 live A to B", b_out, 8'h81);
    check("R6 b_oe", {7'd0, b_oe}, 8'd1);
    check("R6 A undriven", a_out, '0);
    check("R8 inverted live A", b_out_n, 8'h7e);
    sel_a2b = 1'b1;
    settle();
    check("R1 stored A under isolation", b_out, m_ra);
  endtask

  task automatic t_capture_hold();
    // capture A while driving A (opposite direction): R1 independence
    @(negedge clk);
    dir = 1'b0; a_in = 8'h96;
    capture(1'b1, 1'b0);
    a_in = 8'h11;                      // changed with no strobe
    capture(1'b0, 1'b0);
    @(negedge clk);
    dir = 1'b1; sel_a2b = 1'b1;
    settle();
    check("R1 capture then hold", b_out, 8'h96);
    // B capture while driving B, then hold
    b_in = 8'he7;
    capture(1'b0, 1'b1);
    b_in = 8'h22;
    capture(1'b0, 1'b0);
    @(negedge clk);
    dir = 1'b0; sel_b2a = 1'b1;
    settle();
    check("R2 capture then hold", a_out, 8'he7);
  endtask

  task automatic t_select_switch();
    @(negedge clk);
    dir = 1'b0; b_in = 8'h0f; sel_b2a = 1'b1;
    settle();
    check("R9 stored before switch", a_out, m_rb);
    sel_b2a = 1'b0;
    #0.2;
    check("R9 live right after switch", a_out, 8'h0f);
    sel_b2a = 1'b1;
    #0.2;
    check("R9 stored right after switch back", a_out, m_rb);
  endtask

  task automatic t_reset_clears();
    @(negedge clk);
    rst_n = 1'b0;
    #0.5;
    m_ra = '0; m_rb = '0;
    oe_n = 1'b0; dir = 1'b1; sel_a2b = 1'b1;
    #0.5;
    check("R3 async clear A", b_out, '0);
    @(negedge clk);
    rst_n = 1'b1;
    dir = 1'b0; sel_b2a = 1'b1;
    settle();
    check("R3 async clear B", a_out, '0);
  endtask

  initial begin
    rst_n = 1'b0; a_in = '0; b_in = '0; cap_a = 1'b0; cap_b = 1'b0;
    sel_a2b = 1'b0; sel_b2a = 1'b0; oe_n = 1'b1; dir = 1'b0;
    m_ra = '0; m_rb = '0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    t_reset();
    t_isolation();
    t_live_and_stored_to_a();
    t_live_and_stored_to_b();
    t_capture_hold();
    t_select_switch();
    t_reset_clears();
    $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
    $finish;
  end

  initial begin
    #40000;
    n_checks++;
    n_fail++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
    $finish;
  end
endmodule